// File: doc/BRIEF.md
# Quadrature Colour Subcarrier Generator

This block synthesises the colour subcarrier for a composite video encoder running at 27 MHz. A 32-bit phase accumulator adds a programmed frequency increment on every clock. The top 11 bits of the accumulator form a phase word. Sine and cosine samples are read for that phase from a single stored quarter wave, and the remaining quadrants are rebuilt by reflecting the table index and negating the result. The chroma modulator downstream multiplies these samples by its colour-difference data.

A third channel carries the burst reference for each line. In PAL mode it sits 135° or 225° ahead of the subcarrier, and a line-alternation input chooses between the two. In NTSC mode it sits 180° ahead. In NTSC mode a hue value shifts the phase of all three channels, and in PAL mode the hue value is ignored. A blanking input forces the burst channel to zero on lines that must not carry burst. A line-start pulse clears the accumulator, so that the subcarrier phase is known at the start of the line.

Top module: `color_subcarrier_gen`

## Requirements
- R1: While rst_ni is low, sin_o, cos_o and burst_o are zero and the accumulator is zero.
- R2: On each clock without line_start_i, the accumulator advances by phase_inc_i modulo 2^32. The phase word p is accumulator bits [31:21].
- R3: Samples are 12-bit two's complement. The value for a phase code q is round(2047*sin(2*pi*(q+0.5)/2048)), within ±1 LSB.
- R4: The quadrant reconstruction is exact. For every q, the sample at q+1024 equals the negated sample at q. For q below 512, the sample at 1023-q equals the sample at q.
- R5: cos_o equals the sine of the same sample phase advanced by 512 codes (90°).
- R6: A clock edge with line_start_i high loads zero into the accumulator instead of advancing it.
- R7: Outputs are registered. A sample appears two clock edges after the edge that produced its accumulator value. pal_mode_i, pal_alt_i, hue_i and burst_blank_i are taken at the same edge as that accumulator value is read.
- R8: With pal_mode_i=1, burst_o is the sine at p+768 (135°) when pal_alt_i=0, and at p+1280 (225°) when pal_alt_i=1.
- R9: With pal_mode_i=0, the sample phase for sin_o and cos_o is p+8*hue_i. burst_o is the sine at p+8*hue_i+1024 (180°).
- R10: With pal_mode_i=1, hue_i has no effect on sin_o, cos_o or burst_o.
- R11: burst_blank_i high forces burst_o to zero with the same latency as the phase, and leaves sin_o and cos_o unchanged.
- R12: pal_mode_i=1 selects PAL behaviour and pal_mode_i=0 selects NTSC behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 27 MHz sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_inc_i | input | 32 | Frequency increment added to the accumulator on each clock |
| pal_mode_i | input | 1 | 1 = PAL, 0 = NTSC |
| pal_alt_i | input | 1 | Line alternation select for the PAL burst phase |
| hue_i | input | 8 | NTSC phase offset, in steps of 8 phase codes |
| line_start_i | input | 1 | Clears the accumulator at this edge |
| burst_blank_i | input | 1 | Suppresses the burst channel |
| sin_o | output | 12 | Subcarrier sine sample |
| cos_o | output | 12 | Subcarrier cosine sample |
| burst_o | output | 12 | Burst reference sample |

## Verification
The hardest property to reach from the ports is exact quadrant symmetry. It needs the sine output at every one of the 2048 phase codes, while a normal subcarrier increment visits only a scattered subset of them. The stimulus first clears the accumulator with a line-start pulse. It then runs a long stretch with an increment of half a phase code per clock in NTSC mode with zero hue, so that every code appears twice. The bench records the sample seen at each code and then compares the mirror and negation pairs exactly. Line-start pulses and wrapping increments are mixed into the other stretches, so that the scoreboard's model accumulator must follow both clears and overflow.

// File: rtl/sc_pkg.sv
package sc_pkg;
  parameter int ACC_W = 32;
  parameter int PH_W  = 11;
  parameter int SMP_W = 12;
  parameter int HUE_W = 8;
  parameter int NCH   = 3;
  localparam int CH_SIN   = 0;
  localparam int CH_COS   = 1;
  localparam int CH_BURST = 2;
endpackage

// File: rtl/sc_phase_acc.sv
module sc_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] inc_i,
  input  logic             clr_i,
  output logic [PH_W-1:0]  ph_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= acc_q + inc_i;
  end

  assign ph_o = acc_q[ACC_W-1 -: PH_W];

  // R2
  acc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> acc_q == $past(acc_q + inc_i));

  // R6
  acc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == '0);
endmodule

// File: rtl/sc_quarter_rom.sv
module sc_quarter_rom #(
  parameter int IDX_W = 9,
  parameter int MAG_W = 11
) (
  input  logic [IDX_W-1:0] addr_i,
  output logic [MAG_W-1:0] data_o
);
  localparam int    DEPTH  = 1 << IDX_W;
  localparam longint AMP   = (longint'(1) << MAG_W) - 1;
  localparam longint PI_Q30 = 64'd3373259426;

  // Taylor series in Q30 at the centre of each table cell
  function automatic logic [MAG_W-1:0] qsin(input int i);
    longint x, x2, t, s, r;
    x  = (longint'(2 * i + 1) * PI_Q30) / longint'(4 * DEPTH);
    x2 = (x * x) >>> 30;
    t  = x;
    s  = x;
    for (int k = 1; k <= 4; k++) begin
      t = -(((t * x2) >>> 30) / longint'((2 * k) * (2 * k + 1)));
      s = s + t;
    end
    r = (s * AMP + (longint'(1) << 29)) >>> 30;
    if (r > AMP) r = AMP;
    return r[MAG_W-1:0];
  endfunction

  logic [MAG_W-1:0] tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tab
    localparam logic [MAG_W-1:0] VAL = qsin(g);
    assign tab[g] = VAL;
  end

  assign data_o = tab[addr_i];
endmodule

// File: rtl/sc_wave_lookup.sv
module sc_wave_lookup #(
  parameter int PH_W  = 11,
  parameter int SMP_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             kill_i,
  output logic [SMP_W-1:0] smp_o
);
  localparam int IDX_W = PH_W - 2;
  localparam int MAG_W = SMP_W - 1;

  logic [IDX_W-1:0] s1_idx_q;
  logic             s1_neg_q, s1_kill_q;
  logic [MAG_W-1:0] mag;
  logic [SMP_W-1:0] smp_q;

  // bit PH_W-2 odd quadrant -> mirror index; bit PH_W-1 -> negative half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_idx_q  <= '0;
      s1_neg_q  <= 1'b0;
      s1_kill_q <= 1'b0;
    end else begin
      s1_idx_q  <= phase_i[PH_W-2] ? ~phase_i[IDX_W-1:0] : phase_i[IDX_W-1:0];
      s1_neg_q  <= phase_i[PH_W-1];
      s1_kill_q <= kill_i;
    end
  end

  sc_quarter_rom #(.IDX_W(IDX_W), .MAG_W(MAG_W)) u_rom (
    .addr_i(s1_idx_q),
    .data_o(mag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        smp_q <= '0;
    else if (s1_kill_q) smp_q <= '0;
    else if (s1_neg_q)  smp_q <= -{1'b0, mag};
    else                smp_q <= {1'b0, mag};
  end

  assign smp_o = smp_q;

  // R4
  neg_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s1_kill_q && s1_neg_q) |=> smp_o[SMP_W-1]);

  // R4
  pos_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s1_kill_q && !s1_neg_q) |=> (!smp_o[SMP_W-1] && smp_o != '0));
endmodule

// File: rtl/color_subcarrier_gen.sv
module color_subcarrier_gen
  import sc_pkg::*;
#(
  parameter int P_ACC_W = ACC_W,
  parameter int P_PH_W  = PH_W,
  parameter int P_SMP_W = SMP_W,
  parameter int P_HUE_W = HUE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [P_ACC_W-1:0] phase_inc_i,
  input  logic               pal_mode_i,
  input  logic               pal_alt_i,
  input  logic [P_HUE_W-1:0] hue_i,
  input  logic               line_start_i,
  input  logic               burst_blank_i,
  output logic [P_SMP_W-1:0] sin_o,
  output logic [P_SMP_W-1:0] cos_o,
  output logic [P_SMP_W-1:0] burst_o
);
  localparam int OCT   = 1 << (P_PH_W - 3);
  localparam logic [P_PH_W-1:0] QTR  = P_PH_W'(2 * OCT);
  localparam logic [P_PH_W-1:0] HALF = P_PH_W'(4 * OCT);
  localparam logic [P_PH_W-1:0] B135 = P_PH_W'(3 * OCT);
  localparam logic [P_PH_W-1:0] B225 = P_PH_W'(5 * OCT);

  logic [P_PH_W-1:0]  ph, ph_ntsc, hue_off;
  logic [P_PH_W-1:0]  ch_ph   [NCH];
  logic [NCH-1:0]     ch_kill;
  logic [P_SMP_W-1:0] ch_smp  [NCH];

  sc_phase_acc #(.ACC_W(P_ACC_W), .PH_W(P_PH_W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (phase_inc_i),
    .clr_i (line_start_i),
    .ph_o  (ph)
  );

  assign hue_off = {hue_i, {(P_PH_W - P_HUE_W){1'b0}}};

  always_comb begin
    ph_ntsc          = ph + hue_off;
    ch_ph[CH_SIN]    = pal_mode_i ? ph : ph_ntsc;
    ch_ph[CH_COS]    = ch_ph[CH_SIN] + QTR;
    ch_ph[CH_BURST]  = pal_mode_i ? ph + (pal_alt_i ? B225 : B135)
                                  : ph_ntsc + HALF;
    ch_kill          = '0;
    ch_kill[CH_BURST] = burst_blank_i;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    sc_wave_lookup #(.PH_W(P_PH_W), .SMP_W(P_SMP_W)) u_lk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .phase_i(ch_ph[g]),
      .kill_i (ch_kill[g]),
      .smp_o  (ch_smp[g])
    );
  end

  assign sin_o   = ch_smp[CH_SIN];
  assign cos_o   = ch_smp[CH_COS];
  assign burst_o = ch_smp[CH_BURST];

  // R11
  burst_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_blank_i |=> ##1 (burst_o == '0));
endmodule

// File: tb/color_subcarrier_gen_tb.sv
module color_subcarrier_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] phase_inc_i = '0;
  logic        pal_mode_i = 1'b0, pal_alt_i = 1'b0;
  logic [7:0]  hue_i = '0;
  logic        line_start_i = 1'b0, burst_blank_i = 1'b0;
  logic [11:0] sin_o, cos_o, burst_o;

  always #10 clk_i = ~clk_i;

  color_subcarrier_gen dut_i (
    .clk_i, .rst_ni, .phase_inc_i, .pal_mode_i, .pal_alt_i, .hue_i,
    .line_start_i, .burst_blank_i, .sin_o, .cos_o, .burst_o
  );

  typedef struct {
    int    due;
    int    es, ec, eb, btol, sph;
    bit    rec;
    string tag;
  } item_t;

  item_t       sbq[$];
  int          got_sin[int];
  int          cyc = 0, checks = 0, fails = 0;
  logic [31:0] acc_m = '0;
  bit          done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int wave(input int p);
    real a, v;
    a = 2.0 * 3.14159265358979 * (real'(p % 2048) + 0.5) / 2048.0;
    v = 2047.0 * $sin(a);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    item_t it;
    if (rst_ni) begin
      while (sbq.size() > 0 && sbq[0].due == cyc) begin
        it = sbq.pop_front();
        chk(it.tag, "sin", int'($signed(sin_o)), it.es, 1);
        chk(it.tag, "cos", int'($signed(cos_o)), it.ec, 1);
        chk(it.tag, "burst", int'($signed(burst_o)), it.eb, it.btol);
        if (it.rec) got_sin[it.sph] = int'($signed(sin_o));
      end
    end
  end

  // driver
  task automatic step(input logic [31:0] inc, input bit pal, input bit alt, input logic [7:0] hue,
                      input bit blank, input bit ls, input bit rec, input string tag);
    item_t it;
    int p, pn, sp;
    @(negedge clk_i); #1;
    phase_inc_i = inc; pal_mode_i = pal; pal_alt_i = alt; hue_i = hue;
    burst_blank_i = blank; line_start_i = ls;
    p  = int'(acc_m[31:21]);
    pn = (p + 8 * int'(hue)) % 2048;
    sp = pal ? p : pn;
    it.due  = cyc + 2;
    it.es   = wave(sp);
    it.ec   = wave(sp + 512);
    it.eb   = blank ? 0 : (pal ? wave(p + (alt ? 1280 : 768)) : wave(pn + 1024));
    it.btol = blank ? 0 : 1;
    it.sph  = sp;
    it.rec  = rec;
    it.tag  = tag;
    sbq.push_back(it);
    acc_m = ls ? 32'h0 : acc_m + inc;
  endtask

  localparam logic [31:0] INC_NTSC = 32'h21F0_7C1F;
  localparam logic [31:0] INC_PAL  = 32'h2A09_8ACB;

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "sin in reset", int'(sin_o), 0, 0);
    chk("R1", "cos in reset", int'(cos_o), 0, 0);
    chk("R1", "burst in reset", int'(burst_o), 0, 0);
    @(negedge clk_i); #1 rst_ni = 1'b1;

    // R3 R5 R7 R12: NTSC subcarrier, zero hue
    for (int i = 0; i < 300; i++) step(INC_NTSC, 0, 0, 8'h00, 0, 0, 0, "R3 R5 R7 R12");
    // R8 R10: PAL with alternating lines and hue that must be ignored
    for (int i = 0; i < 300; i++) step(INC_PAL, 1, (i / 37) % 2 == 1, 8'h5A, 0, 0, 0, "R8 R10");
    // R9: hue offsets
    for (int i = 0; i < 60; i++) step(INC_NTSC, 0, 0, 8'h20, 0, 0, 0, "R9");
    for (int i = 0; i < 60; i++) step(INC_NTSC, 0, 1, 8'hA0, 0, 0, 0, "R9");
    for (int i = 0; i < 60; i++) step(INC_NTSC, 0, 0, 8'hFF, 0, 0, 0, "R9");
    // R6: line start clears
    for (int i = 0; i < 200; i++) step(INC_NTSC, 0, 0, 8'h10, 0, (i % 17) == 5, 0, "R6");
    // R2: wrap and stall
    for (int i = 0; i < 40; i++) step(32'hF000_0000, 0, 0, 8'h00, 0, 0, 0, "R2");
    for (int i = 0; i < 10; i++) step(32'h0, 1, 1, 8'h00, 0, 0, 0, "R2");
    for (int i = 0; i < 40; i++) step(32'hFFFF_FFFF - i, 0, 0, 8'h00, 0, 0, 0, "R2");
    // R11: burst blanking toggles, sin/cos unaffected
    for (int i = 0; i < 200; i++) step(INC_PAL, 1, (i / 11) % 2 == 1, 8'h00, (i / 7) % 2 == 1, 0, 0, "R11");
    for (int i = 0; i < 60; i++) step(INC_NTSC, 0, 0, 8'h33, (i % 3) == 0, 0, 0, "R11");
    // R4: sweep every phase code
    step(32'h0, 0, 0, 8'h00, 0, 1, 0, "R6");
    for (int i = 0; i < 4200; i++) step(32'h0010_0000, 0, 0, 8'h00, 0, 0, 1, "R3 R4");
    repeat (4) @(negedge clk_i);

    for (int p = 0; p < 1024; p++) begin
      if (got_sin.exists(p) && got_sin.exists(p + 1024))
        chk("R4", $sformatf("negation at %0d", p), got_sin[p + 1024], -got_sin[p], 0);
      else
        chk("R4", $sformatf("coverage at %0d", p), 0, 1, 0);
    end
    for (int p = 0; p < 512; p++)
      if (got_sin.exists(p) && got_sin.exists(1023 - p))
        chk("R4", $sformatf("mirror at %0d", p), got_sin[1023 - p], got_sin[p], 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule